// File: doc/BRIEF.md
# Key-Locked Watchdog Timer with Reset-Reason Capture

A watchdog timer for a power-management device. A 32-bit down-counter advances on a one-cycle enable pulse (`tick_i`) that comes from a 32.768 kHz time base and is synchronous to the register clock. For example, a 50 ms timeout is a load value of 1638. Software reaches the block through a small 16-bit register file with a single-cycle write strobe and a combinational read path.

The load and control registers are write-protected. A write to them is dropped unless the 16-bit key 0xE551 was last written to the lock register. The usual sequence is: unlock, program the load value, set run and reset-enable together, then lock again by writing any other value to the lock register.

When the count expires with reset enabled, the block raises a reset request for a fixed number of cycles. It also stores the watchdog code 0xF0 in a reset-reason byte. That byte is cleared only by power-on reset, so software can read the reason after the reboot. When the count expires with reset disabled, the block sets a sticky timeout flag instead.

Top module: `pmic_wdog`

## Requirements
- R1: After reset the block is locked (offset 0x20 reads 0), the load, control, counter and reason registers read 0, and `rst_req_o` and `timeout_o` are low.
- R2: While locked, writes to load-low (0x00), load-high (0x04) and control (0x08) leave those registers unchanged, and reads still return their current contents.
- R3: Writing 0xE551 to offset 0x20 unlocks the block, and offset 0x20 then reads 1 in bit 0. Writing any other value to 0x20, such as 0x1AAE, locks the block again.
- R4: The 32-bit load value is bits [15:0] from offset 0x00 and bits [31:16] from offset 0x04. The counter reads back as bits [15:0] at offset 0x0C and bits [31:16] at offset 0x10.
- R5: The control register at 0x08 has run in bit 1, new-load in bit 2 and reset-enable in bit 3. New-load always reads 0. Writing new-load as 1, or setting run when it was 0, copies the load value into the counter. While run is set, each tick decrements the counter by one, with a borrow across the 16-bit halves. While run is clear, the counter holds.
- R6: With reset-enable set, the tick that would take the counter from 1 to 0 is the expiry. After that edge, `rst_req_o` is high for exactly RST_CYCLES cycles and the counter reloads from the load value.
- R7: The reset-reason byte at offset 0x24 accepts software writes whether the block is locked or not, and keeps its value until it is overwritten. An expiry with reset-enable set writes 0xF0 into it.
- R8: With reset-enable clear, an expiry raises `timeout_o` (also offset 0x14 bit 0), does not raise `rst_req_o` and leaves the reason byte unchanged. The flag stays set until the next load of the counter clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| tick_i | input | 1 | One-cycle 32.768 kHz count enable |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| rst_req_o | output | 1 | System reset request pulse |
| timeout_o | output | 1 | Sticky expiry flag when reset is disabled |

## Verification
The bench builds the block with RST_CYCLES = 3, which differs from the default. The pulse width it counts at the port therefore comes from the parameter and not from a hard-coded constant. Load values of 3 and 5 bring expiry within a few ticks, so both expiry paths, the reload after expiry and the clearing of the sticky flag are all reached quickly. A load of 0x0001_0000 makes the first tick borrow from the upper half of the counter into the lower half.

// File: rtl/pmic_wdog_pkg.sv
package pmic_wdog_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 16;
  localparam int CNT_W    = 2 * DATA_W;
  localparam int REASON_W = 8;

  localparam logic [ADDR_W-1:0] OFS_LOAD_LO = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_LOAD_HI = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_LOCK    = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_REASON  = 8'h24;

  localparam int CTRL_RUN   = 1;
  localparam int CTRL_NEW   = 2;
  localparam int CTRL_RSTEN = 3;

  localparam logic [DATA_W-1:0]   UNLOCK_KEY  = 16'hE551;
  localparam logic [REASON_W-1:0] REASON_WDOG = 8'hF0;
endpackage

// File: rtl/wdog_regfile.sv
module wdog_regfile
  import pmic_wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              fire_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              timeout_i,
  input  logic              rst_req_i,
  output logic [CNT_W-1:0]  load_o,
  output logic              run_o,
  output logic              rst_en_o,
  output logic              reload_o
);
  logic                unlocked_q;
  logic [CNT_W-1:0]    load_q;
  logic                run_q, rst_en_q;
  logic [REASON_W-1:0] reason_q;

  logic wr_lock, wr_ok, wr_ctrl;
  assign wr_lock = wr_i && (addr_i == OFS_LOCK);
  assign wr_ok   = wr_i && unlocked_q;
  assign wr_ctrl = wr_ok && (addr_i == OFS_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_q <= 1'b0;
      load_q     <= '0;
      run_q      <= 1'b0;
      rst_en_q   <= 1'b0;
      reason_q   <= '0;
    end else begin
      if (wr_lock) unlocked_q <= (wdata_i == UNLOCK_KEY);
      if (wr_ok && addr_i == OFS_LOAD_LO) load_q[DATA_W-1:0]     <= wdata_i;
      if (wr_ok && addr_i == OFS_LOAD_HI) load_q[CNT_W-1:DATA_W] <= wdata_i;
      if (wr_ctrl) begin
        run_q    <= wdata_i[CTRL_RUN];
        rst_en_q <= wdata_i[CTRL_RSTEN];
      end
      // hardware capture wins over a same-cycle software write
      if (fire_i)                                reason_q <= REASON_WDOG;
      else if (wr_i && addr_i == OFS_REASON)     reason_q <= wdata_i[REASON_W-1:0];
    end
  end

  assign reload_o = wr_ctrl && (wdata_i[CTRL_NEW] || (wdata_i[CTRL_RUN] && !run_q));
  assign load_o   = load_q;
  assign run_o    = run_q;
  assign rst_en_o = rst_en_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_LOAD_LO: rdata_o = load_q[DATA_W-1:0];
      OFS_LOAD_HI: rdata_o = load_q[CNT_W-1:DATA_W];
      OFS_CTRL: begin
        rdata_o[CTRL_RUN]   = run_q;
        rdata_o[CTRL_RSTEN] = rst_en_q;
      end
      OFS_CNT_LO:  rdata_o = cnt_i[DATA_W-1:0];
      OFS_CNT_HI:  rdata_o = cnt_i[CNT_W-1:DATA_W];
      OFS_STAT:    rdata_o = {{(DATA_W-2){1'b0}}, rst_req_i, timeout_i};
      OFS_LOCK:    rdata_o = {{(DATA_W-1){1'b0}}, unlocked_q};
      OFS_REASON:  rdata_o = {{(DATA_W-REASON_W){1'b0}}, reason_q};
      default:     rdata_o = '0;
    endcase
  end

  AST_LOCKED_LOAD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_q |=> $stable(load_q) && $stable(run_q) && $stable(rst_en_q)); // R2
  AST_KEY_UNLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_LOCK && wdata_i == UNLOCK_KEY) |=> unlocked_q); // R3
  AST_BAD_KEY_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_LOCK && wdata_i != UNLOCK_KEY) |=> !unlocked_q); // R3
  AST_FIRE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> reason_q == REASON_WDOG); // R7
endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt
  import pmic_wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             rst_en_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             timeout_o,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             timeout_q;
  logic             step, expire;

  assign step   = run_i && tick_i && !reload_i;
  assign expire = step && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      timeout_q <= 1'b0;
    end else begin
      if (reload_i || expire) cnt_q <= load_i;
      else if (step)          cnt_q <= cnt_q - 1'b1;
      if (reload_i)                    timeout_q <= 1'b0;
      else if (expire && !rst_en_i)    timeout_q <= 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign timeout_o = timeout_q;
  assign fire_o    = expire && rst_en_i;

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !reload_i && cnt_q > CNT_W'(1)) |=> cnt_q == $past(cnt_q) - 1'b1); // R5
  AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !reload_i) |=> $stable(cnt_q)); // R5
  AST_TIMEOUT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_q && !reload_i) |=> timeout_q); // R8
endmodule

// File: rtl/wdog_rst_gen.sv
module wdog_rst_gen #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic rst_req_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             left_q <= '0;
    else if (fire_i)         left_q <= CW'(RST_CYCLES);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign rst_req_o = (left_q != '0);

  AST_REQ_NEEDS_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(fire_i)); // R6
  AST_REQ_AFTER_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> rst_req_o); // R6
endmodule

// File: rtl/pmic_wdog.sv
module pmic_wdog
  import pmic_wdog_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o,
  output logic              timeout_o
);
  logic [CNT_W-1:0] load, cnt;
  logic run, rst_en, reload, fire, timeout, rst_req;

  wdog_regfile u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .rdata_o,
    .fire_i(fire), .cnt_i(cnt), .timeout_i(timeout), .rst_req_i(rst_req),
    .load_o(load), .run_o(run), .rst_en_o(rst_en), .reload_o(reload)
  );

  wdog_downcnt u_cnt (
    .clk_i, .rst_ni, .tick_i, .run_i(run), .rst_en_i(rst_en), .reload_i(reload),
    .load_i(load), .cnt_o(cnt), .timeout_o(timeout), .fire_o(fire)
  );

  wdog_rst_gen #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk_i, .rst_ni, .fire_i(fire), .rst_req_o(rst_req)
  );

  assign rst_req_o = rst_req;
  assign timeout_o = timeout;
endmodule

// File: tb/pmic_wdog_test.sv
module pmic_wdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int RST_N = 3;

  logic clk = 0, rst_ni = 0, tick_i = 0, wr_i = 0;
  logic [7:0] addr_i = 0;
  logic [15:0] wdata_i = 0, rdata_o;
  logic rst_req_o, timeout_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmic_wdog #(.RST_CYCLES(RST_N)) uut (
    .clk_i(clk), .rst_ni, .tick_i, .wr_i, .addr_i, .wdata_i,
    .rdata_o, .rst_req_o, .timeout_o
  );

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t exp_q[$];
  logic mon_req = 0;
  int checks = 0, errors = 0;

  function automatic void cmp(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endfunction

  // monitor: pops expected read results as the design presents them
  always @(negedge clk) if (mon_req) begin
    item_t it;
    it = exp_q.pop_front();
    cmp(it.tag, rdata_o, it.exp);
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(posedge clk); #1; wr_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk); #1; wr_i = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    @(posedge clk); #1; addr_i = a; exp_q.push_back(it); mon_req = 1;
    @(posedge clk); #1; mon_req = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; tick_i = 1;
      @(posedge clk); #1; tick_i = 0;
    end
  endtask

  task automatic port(input string tag, input logic act, input logic exp);
    @(negedge clk); cmp(tag, {15'b0, act}, {15'b0, exp});
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    // R1 reset state
    rd(8'h20, 16'h0000, "R1 lock");
    rd(8'h00, 16'h0000, "R1 load_lo");
    rd(8'h08, 16'h0000, "R1 ctrl");
    rd(8'h24, 16'h0000, "R1 reason");
    port("R1 rst_req", rst_req_o, 1'b0);
    port("R1 timeout", timeout_o, 1'b0);
    // R2 locked writes dropped
    wr(8'h00, 16'h1234);
    rd(8'h00, 16'h0000, "R2 load_lo locked");
    wr(8'h08, 16'h000E);
    rd(8'h08, 16'h0000, "R2 ctrl locked");
    rd(8'h0C, 16'h0000, "R2 counter not loaded");
    // R3 key handling
    wr(8'h20, 16'h1234);
    rd(8'h20, 16'h0000, "R3 wrong key");
    wr(8'h20, 16'hE551);
    rd(8'h20, 16'h0001, "R3 key unlocks");
    // R4 load halves
    wr(8'h00, 16'h0005);
    wr(8'h04, 16'h0001);
    rd(8'h00, 16'h0005, "R4 load_lo");
    rd(8'h04, 16'h0001, "R4 load_hi");
    wr(8'h04, 16'h0000);
    // R5 new-load, hold while stopped
    wr(8'h08, 16'h0004);
    rd(8'h0C, 16'h0005, "R5 new-load copies");
    rd(8'h08, 16'h0000, "R5 new-load reads zero");
    tick(2);
    rd(8'h0C, 16'h0005, "R5 hold when stopped");
    // R7 reason writable
    wr(8'h24, 16'h0040);
    rd(8'h24, 16'h0040, "R7 reason write");
    // R3 relock with inverse key, R2 reads still work
    wr(8'h20, 16'h1AAE);
    rd(8'h20, 16'h0000, "R3 relock");
    wr(8'h00, 16'h0009);
    rd(8'h00, 16'h0005, "R2 locked load keeps value");
    wr(8'h20, 16'hE551);
    // R8 expiry without reset
    wr(8'h00, 16'h0003);
    wr(8'h08, 16'h0002);
    rd(8'h0C, 16'h0003, "R5 run rise reloads");
    tick(1);
    rd(8'h0C, 16'h0002, "R5 decrement");
    tick(2);
    port("R8 timeout set", timeout_o, 1'b1);
    port("R8 no reset", rst_req_o, 1'b0);
    rd(8'h14, 16'h0001, "R8 status bit");
    rd(8'h24, 16'h0040, "R8 reason kept");
    rd(8'h0C, 16'h0003, "R6 reload after expiry");
    tick(1);
    port("R8 timeout sticky", timeout_o, 1'b1);
    wr(8'h08, 16'h0006);
    port("R8 reload clears", timeout_o, 1'b0);
    // R6 expiry with reset
    wr(8'h08, 16'h000A);
    tick(2);
    port("R6 no early reset", rst_req_o, 1'b0);
    tick(1);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); if (rst_req_o) n++;
    end
    cmp("R6 pulse length", 16'(n), 16'(RST_N));
    rd(8'h24, 16'h00F0, "R7 watchdog code");
    port("R6 no timeout flag", timeout_o, 1'b0);
    rd(8'h0C, 16'h0003, "R6 counter reloaded");
    // R7 reason while locked, R2 ctrl locked
    wr(8'h20, 16'h0000);
    wr(8'h24, 16'h0020);
    rd(8'h24, 16'h0020, "R7 reason while locked");
    wr(8'h08, 16'h0000);
    rd(8'h08, 16'h000A, "R2 ctrl locked keeps");
    // R4/R5 upper half and borrow
    wr(8'h20, 16'hE551);
    wr(8'h00, 16'h0000);
    wr(8'h04, 16'h0001);
    wr(8'h08, 16'h000E);
    rd(8'h10, 16'h0001, "R4 counter high");
    rd(8'h0C, 16'h0000, "R4 counter low");
    tick(1);
    rd(8'h0C, 16'hFFFF, "R5 borrow low");
    rd(8'h10, 16'h0000, "R5 borrow high");
    finish_run();
  end
endmodule